// File: doc/BRIEF.md
# Bus-Fault Exception Frame Sequencer

This block is the microsequence a processor core runs once a bus error or an address error has been accepted. It stores a seven-word exception frame on the supervisor stack through a 16-bit bus master port and then loads the handler address from the vector table. After that it performs two prefetches separated by one idle cycle and hands control back to decode. The core supplies the values it needs on entry: the stack pointer, the program counter, the captured status word, the instruction register, the faulting address and that access's attributes (read or write, program or data). It also supplies the vector-table address of the handler.

The frame words are not written in address order. The two halves of the program counter go out on either side of the status word. The function-code word is built from the instruction register and replaces only its low five bits. Every bus access holds its request until an acknowledge arrives. If a second fault arrives while a sequence is in progress, the block halts instead of starting again.

Top module: `ffs_seq`

## Requirements
- R1: After a fault is accepted (`fault_i` high while idle), the bus stays quiet for exactly two cycles. The first frame write is requested in the third cycle.
- R2: With entry stack pointer S, the seven word writes go to these addresses in this order: S-2, S-6, S-4, S-8, S-14, S-10, S-12. Consecutive accesses follow each other with no idle cycle between them.
- R3: The frame contents are as follows. S-2 holds bits 15:0 and S-4 holds bits 31:16 of (program counter - 4). S-6 holds the captured status word unchanged. S-8 holds the instruction register. S-10 holds fault address bits 15:0 and S-12 holds fault address bits 31:16.
- R4: The function-code word at S-14 has these low bits. Bit 4 is 1 for a faulting read and 0 for a write. Bit 3 is 1 for a program access. Bit 2 copies status bit 13 (supervisor). Bits 1:0 are 2'b10 for a program access and 2'b01 for a data access.
- R5: Bits 15:5 of the function-code word equal bits 15:5 of the instruction register.
- R6: A request holds its address, direction and write data stable until `bus_ack_i` is seen high at a clock edge.
- R7: After the last frame write, `sp_o` equals S-14.
- R8: Two word reads follow the writes: vector address V returns the new program counter's bits 31:16, and V+2 returns its bits 15:0. `pc_o` then shows the 32-bit result.
- R9: After the vector reads, the block prefetches at the new program counter, leaves one idle cycle, and prefetches at the new program counter + 2. `done_o` pulses for one cycle after that read completes. `busy_o` is high from acceptance until then and low whenever no sequence runs.
- R10: A fault arriving while `busy_o` is high sets `halt_o`, which stays set until reset. From the next cycle on there are no further bus requests, and `busy_o` is low.
- R11: `status_o` shows the status word captured at acceptance with bit 13 (supervisor) set and bit 15 (trace) cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Fault accepted: start request when idle, halt cause when busy |
| sp_i | input | 32 | Stack pointer at entry |
| pc_i | input | 32 | Current program counter (includes prefetch) |
| sr_i | input | 16 | Captured status word before the fault |
| ir_i | input | 16 | Instruction register |
| fault_addr_i | input | 32 | Address of the faulting access |
| fault_rd_i | input | 1 | Faulting access was a read |
| fault_prog_i | input | 1 | Faulting access was a program fetch |
| vec_addr_i | input | 32 | Vector-table address of the handler |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = word write, 0 = word read |
| bus_addr_o | output | 32 | Byte address of the word access |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 16 | Read data |
| sp_o | output | 32 | Stack pointer (S-14 once the frame is written) |
| pc_o | output | 32 | New program counter from the vector table |
| status_o | output | 16 | Working status word: supervisor on, trace off |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| halt_o | output | 1 | Sticky halt after a nested fault |

## Verification
The hardest situation to reach from the ports is a second fault arriving in the middle of the frame. The bench brings it about by holding off the acknowledge of a chosen write and raising `fault_i` while that request is pending. It then checks that the bus goes quiet and that the halt persists. The out-of-order frame layout and the function-code bits are covered by stimulus that steps through all four read/write and program/data combinations with the supervisor bit both set and clear. Random acknowledge delays are mixed in so that every hold-until-acknowledge window gets exercised.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 16;
    localparam int FRAME_WORDS = 7;
    localparam int FRAME_BYTES = FRAME_WORDS * (DATA_W / 8);
    localparam int SUP_BIT     = 13;
    localparam int TRACE_BIT   = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WR,
        ST_VEC,
        ST_PF1,
        ST_GAP,
        ST_PF2,
        ST_HALT
    } ffs_state_e;
endpackage

// File: rtl/ffs_fcode.sv
module ffs_fcode
    import ffs_pkg::*;
(
    input  logic [DATA_W-1:0] ir_i,
    input  logic              rd_i,
    input  logic              prog_i,
    input  logic              sup_i,
    output logic [DATA_W-1:0] fc_o
);
    // Upper bits are left over from the instruction word; low five are rebuilt.
    always_comb begin
        fc_o      = ir_i;
        fc_o[4]   = rd_i;
        fc_o[3]   = prog_i;
        fc_o[2]   = sup_i;
        fc_o[1:0] = prog_i ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/ffs_slot_map.sv
module ffs_slot_map
    import ffs_pkg::*;
(
    input  logic [2:0]        step_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] pc_adj_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [DATA_W-1:0] ir_i,
    input  logic [DATA_W-1:0] fc_i,
    input  logic [ADDR_W-1:0] fa_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    // Write step -> (offset below entry stack pointer, source word).
    always_comb begin
        unique case (step_i)
            3'd0: begin addr_o = sp_i - 32'd2;  data_o = pc_adj_i[15:0];  end
            3'd1: begin addr_o = sp_i - 32'd6;  data_o = sr_i;            end
            3'd2: begin addr_o = sp_i - 32'd4;  data_o = pc_adj_i[31:16]; end
            3'd3: begin addr_o = sp_i - 32'd8;  data_o = ir_i;            end
            3'd4: begin addr_o = sp_i - 32'd14; data_o = fc_i;            end
            3'd5: begin addr_o = sp_i - 32'd10; data_o = fa_i[15:0];      end
            3'd6: begin addr_o = sp_i - 32'd12; data_o = fa_i[31:16];     end
            default: begin addr_o = '0; data_o = '0; end
        endcase
    end
endmodule

// File: rtl/ffs_seq.sv
module ffs_seq
    import ffs_pkg::*;
#(
    parameter int PRE_IDLE = 2,   // idle cycles before the first write (>= 1)
    parameter int GAP_IDLE = 1,   // idle cycles between the prefetches (>= 1)
    parameter int PF_ADJ   = 4    // prefetch discount on the stacked PC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [DATA_W-1:0] ir_i,
    input  logic [ADDR_W-1:0] fault_addr_i,
    input  logic              fault_rd_i,
    input  logic              fault_prog_i,
    input  logic [ADDR_W-1:0] vec_addr_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] status_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              halt_o
);
    localparam int CNT_MAX = (FRAME_WORDS - 1 > PRE_IDLE) ?
                             ((FRAME_WORDS - 1 > GAP_IDLE) ? FRAME_WORDS - 1 : GAP_IDLE) :
                             ((PRE_IDLE > GAP_IDLE) ? PRE_IDLE : GAP_IDLE);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_IDLE - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_IDLE - 1);
    localparam logic [CW-1:0] WR_LAST  = CW'(FRAME_WORDS - 1);
    localparam logic [ADDR_W-1:0] WORD_B = ADDR_W'(DATA_W / 8);

    typedef struct packed {
        ffs_state_e        st;
        logic [CW-1:0]     step;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc_adj;
        logic [ADDR_W-1:0] fa;
        logic [ADDR_W-1:0] vec;
        logic [ADDR_W-1:0] npc;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] stat;
        logic              rd;
        logic              prog;
        logic              done;
        logic              halt;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] fc_word;
    logic [ADDR_W-1:0] slot_addr;
    logic [DATA_W-1:0] slot_data;
    logic              busy;

    ffs_fcode u_fcode (
        .ir_i   (r_q.ir),
        .rd_i   (r_q.rd),
        .prog_i (r_q.prog),
        .sup_i  (r_q.sr[SUP_BIT]),
        .fc_o   (fc_word)
    );

    ffs_slot_map u_slot (
        .step_i   (r_q.step[2:0]),
        .sp_i     (r_q.sp),
        .pc_adj_i (r_q.pc_adj),
        .sr_i     (r_q.sr),
        .ir_i     (r_q.ir),
        .fc_i     (fc_word),
        .fa_i     (r_q.fa),
        .addr_o   (slot_addr),
        .data_o   (slot_data)
    );

    assign busy = (r_q.st != ST_IDLE) && (r_q.st != ST_HALT);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fault_i) begin
                    r_d.st     = ST_PRE;
                    r_d.step   = '0;
                    r_d.sp     = sp_i;
                    r_d.pc_adj = pc_i - ADDR_W'(PF_ADJ);
                    r_d.fa     = fault_addr_i;
                    r_d.vec    = vec_addr_i;
                    r_d.sr     = sr_i;
                    r_d.ir     = ir_i;
                    r_d.rd     = fault_rd_i;
                    r_d.prog   = fault_prog_i;
                    r_d.stat   = sr_i;
                    r_d.stat[SUP_BIT]   = 1'b1;
                    r_d.stat[TRACE_BIT] = 1'b0;
                end
            end
            ST_PRE: begin
                if (r_q.step == PRE_LAST) begin
                    r_d.st   = ST_WR;
                    r_d.step = '0;
                end else begin
                    r_d.step = r_q.step + 1'b1;
                end
            end
            ST_WR: begin
                if (bus_ack_i) begin
                    if (r_q.step == WR_LAST) begin
                        r_d.st   = ST_VEC;
                        r_d.step = '0;
                        r_d.sp   = r_q.sp - ADDR_W'(FRAME_BYTES);
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end
            ST_VEC: begin
                if (bus_ack_i) begin
                    if (r_q.step[0]) begin
                        r_d.npc[15:0] = bus_rdata_i;
                        r_d.st        = ST_PF1;
                        r_d.step      = '0;
                    end else begin
                        r_d.npc[31:16] = bus_rdata_i;
                        r_d.step       = r_q.step + 1'b1;
                    end
                end
            end
            ST_PF1: begin
                if (bus_ack_i) begin
                    r_d.st   = ST_GAP;
                    r_d.step = '0;
                end
            end
            ST_GAP: begin
                if (r_q.step == GAP_LAST) r_d.st = ST_PF2;
                else                      r_d.step = r_q.step + 1'b1;
            end
            ST_PF2: begin
                if (bus_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_HALT;
        endcase
        // A nested fault stops everything.
        if (busy && fault_i) begin
            r_d.st   = ST_HALT;
            r_d.halt = 1'b1;
            r_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (r_q.st)
            ST_WR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = slot_addr;
                bus_wdata_o = slot_data;
            end
            ST_VEC: begin
                bus_req_o  = 1'b1;
                bus_addr_o = r_q.step[0] ? r_q.vec + WORD_B : r_q.vec;
            end
            ST_PF1: begin
                bus_req_o  = 1'b1;
                bus_addr_o = r_q.npc;
            end
            ST_PF2: begin
                bus_req_o  = 1'b1;
                bus_addr_o = r_q.npc + WORD_B;
            end
            default: ;
        endcase
    end

    assign sp_o     = r_q.sp;
    assign pc_o     = r_q.npc;
    assign status_o = r_q.stat;
    assign busy_o   = busy;
    assign done_o   = r_q.done;
    assign halt_o   = r_q.halt;
endmodule

// File: rtl/ffs_seq_chk.sv
module ffs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fault_i,
    input logic        bus_req_o,
    input logic        bus_we_o,
    input logic [31:0] bus_addr_o,
    input logic [15:0] bus_wdata_o,
    input logic        bus_ack_i,
    input logic [31:0] sp_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        halt_o
);
    // R1: the cycle busy rises carries no request
    assert_quiet_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !bus_req_o);

    // R2: every write lands inside the 14-byte frame below the stack pointer
    assert_frame_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o) |->
            ((sp_o - bus_addr_o) >= 32'd2 && (sp_o - bus_addr_o) <= 32'd14 && !bus_addr_o[0]));

    // R6: a pending request does not move until acknowledged
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !fault_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

    // R9: done is a single-cycle pulse outside the busy window
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_noreq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    // R10: halt is sticky and silent
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!bus_req_o && !busy_o));
endmodule

bind ffs_seq ffs_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .sp_o        (sp_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .halt_o      (halt_o)
);

// File: tb/ffs_seq_tb.sv
`timescale 1ns/1ps
module ffs_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_i = 1'b0;
    logic [31:0] sp_i = '0, pc_i = '0, fault_addr_i = '0, vec_addr_i = '0;
    logic [15:0] sr_i = '0, ir_i = '0;
    logic        fault_rd_i = 1'b0, fault_prog_i = 1'b0;
    logic        bus_req_o, bus_we_o, bus_ack_i = 1'b0;
    logic [31:0] bus_addr_o, sp_o, pc_o;
    logic [15:0] bus_wdata_o, bus_rdata_i = '0, status_o;
    logic        busy_o, done_o, halt_o;

    int total = 0;
    int bad   = 0;

    logic        e_we   [11];
    logic [31:0] e_addr [11];
    logic [15:0] e_data [11];

    always #4 clk = ~clk;

    ffs_seq u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] fc_of(input logic [15:0] ir, input logic [15:0] sr,
                                          input logic rd, input logic prog);
        return {ir[15:5], rd, prog, sr[13], (prog ? 2'b10 : 2'b01)};
    endfunction

    task automatic build_exp(input logic [31:0] s, input logic [31:0] pc, input logic [15:0] sr,
                             input logic [15:0] ir, input logic [31:0] fa, input logic rd,
                             input logic prog, input logic [31:0] v, input logic [31:0] npc);
        logic [31:0] pa;
        pa = pc - 32'd4;
        e_addr[0] = s - 2;  e_data[0] = pa[15:0];
        e_addr[1] = s - 6;  e_data[1] = sr;
        e_addr[2] = s - 4;  e_data[2] = pa[31:16];
        e_addr[3] = s - 8;  e_data[3] = ir;
        e_addr[4] = s - 14; e_data[4] = fc_of(ir, sr, rd, prog);
        e_addr[5] = s - 10; e_data[5] = fa[15:0];
        e_addr[6] = s - 12; e_data[6] = fa[31:16];
        e_addr[7] = v;        e_addr[8]  = v + 2;
        e_addr[9] = npc;      e_addr[10] = npc + 2;
        for (int i = 0; i < 11; i++) begin
            e_we[i] = (i < 7);
            if (i >= 7) e_data[i] = '0;
        end
    endtask

    task automatic run_seq(input logic [31:0] s, input logic [31:0] pc, input logic [15:0] sr,
                           input logic [15:0] ir, input logic [31:0] fa, input logic rd,
                           input logic prog, input logic [31:0] v, input logic [31:0] npc,
                           input int halt_at);
        int idx, idle, wt, cyc;
        bit seen, ackd, halted;
        build_exp(s, pc, sr, ir, fa, rd, prog, v, npc);
        @(negedge clk);
        sp_i = s; pc_i = pc; sr_i = sr; ir_i = ir; fault_addr_i = fa;
        fault_rd_i = rd; fault_prog_i = prog; vec_addr_i = v; fault_i = 1'b1;
        @(negedge clk);
        fault_i = 1'b0;
        idx = 0; idle = 0; wt = $urandom % 3; cyc = 0; seen = 0; ackd = 0; halted = 0;
        while (1) begin
            if (ackd) begin
                idx++; ackd = 0; bus_ack_i = 1'b0; seen = 0; wt = $urandom % 3;
            end
            if (done_o || idx >= 11) break;
            if (bus_req_o) begin
                if (!seen) begin
                    seen = 1;
                    if (idx == 0)       chk(idle == 2, "R1 idle before first write", idle, 2);
                    else if (idx == 10) chk(idle == 1, "R9 gap before second prefetch", idle, 1);
                    else                chk(idle == 0, "R2 back-to-back access", idle, 0);
                    idle = 0;
                    chk(busy_o, "R9 busy during access", {31'd0, busy_o}, 1);
                    chk(bus_we_o == e_we[idx], $sformatf("R2 direction idx %0d", idx), {31'd0, bus_we_o}, {31'd0, e_we[idx]});
                    chk(bus_addr_o == e_addr[idx],
                        $sformatf("%s address idx %0d", (idx < 7) ? "R2" : (idx < 9) ? "R8" : "R9", idx),
                        bus_addr_o, e_addr[idx]);
                    if (idx == 4) begin
                        chk(bus_wdata_o[4:0] == e_data[4][4:0], "R4 function-code low bits",
                            {27'd0, bus_wdata_o[4:0]}, {27'd0, e_data[4][4:0]});
                        chk(bus_wdata_o[15:5] == e_data[4][15:5], "R5 function-code upper bits",
                            {21'd0, bus_wdata_o[15:5]}, {21'd0, e_data[4][15:5]});
                    end else if (idx < 7) begin
                        chk(bus_wdata_o == e_data[idx], $sformatf("R3 frame data idx %0d", idx),
                            {16'd0, bus_wdata_o}, {16'd0, e_data[idx]});
                    end
                    if (idx == halt_at) begin
                        fault_i = 1'b1;
                        halted = 1;
                    end
                end
                if (halted) break;
                if (wt == 0) begin
                    bus_ack_i   = 1'b1;
                    bus_rdata_i = (idx == 7) ? npc[31:16] : (idx == 8) ? npc[15:0] : 16'($urandom);
                    ackd = 1;
                end else begin
                    wt--;
                end
            end else begin
                idle++;
            end
            cyc++;
            if (cyc > 300) begin
                chk(0, "R9 sequence did not finish", cyc, 300);
                break;
            end
            @(negedge clk);
        end
        if (halted) begin
            @(negedge clk);
            fault_i = 1'b0;
            chk(halt_o, "R10 halt set", {31'd0, halt_o}, 1);
            chk(!busy_o, "R10 busy cleared", {31'd0, busy_o}, 0);
            for (int k = 0; k < 4; k++) begin
                chk(!bus_req_o, "R10 no request after halt", {31'd0, bus_req_o}, 0);
                @(negedge clk);
            end
            chk(halt_o, "R10 halt sticky", {31'd0, halt_o}, 1);
            return;
        end
        chk(idx == 11, "R9 access count", idx, 11);
        chk(done_o, "R9 done pulse", {31'd0, done_o}, 1);
        chk(!busy_o, "R9 busy low at done", {31'd0, busy_o}, 0);
        chk(sp_o == s - 32'd14, "R7 final stack pointer", sp_o, s - 32'd14);
        chk(pc_o == npc, "R8 new program counter", pc_o, npc);
        chk(status_o == {1'b0, sr[14], 1'b1, sr[12:0]}, "R11 working status",
            {16'd0, status_o}, {16'd0, 1'b0, sr[14], 1'b1, sr[12:0]});
        @(negedge clk);
        chk(!done_o, "R9 done lasts one cycle", {31'd0, done_o}, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s, pc, fa, v, npc;
        logic [15:0] sr, ir;
        void'($urandom(32'h5eed_0042));
        do_reset();
        @(negedge clk);
        chk(!busy_o && !bus_req_o && !done_o && !halt_o, "R9 reset idle",
            {28'd0, busy_o, bus_req_o, done_o, halt_o}, 0);
        chk(sp_o == 0 && pc_o == 0, "R7 reset outputs", sp_o | pc_o, 0);

        // directed: all read/write x program/data combinations, supervisor bit both ways
        for (int c = 0; c < 8; c++) begin
            run_seq(32'h0000_2000 + 32'(c * 64), 32'h0000_1004 + 32'(c * 2),
                    (c[2] ? 16'hA71F : 16'h4F00), 16'hBEEF ^ 16'(c * 16'h1111),
                    32'hDEAD_0001 + 32'(c), c[0], c[1], 32'h0000_0008, 32'h0040_0100, -1);
        end

        // directed: stacked PC wrap when pc < 4, frame at low stack
        run_seq(32'h0000_000E, 32'h0000_0002, 16'h2000, 16'h0000, 32'hFFFF_FFFF,
                1'b1, 1'b0, 32'h0000_000C, 32'hFFFF_FFFE, -1);

        // random
        for (int n = 0; n < 30; n++) begin
            s   = ($urandom | 32'h100) & ~32'h1;
            pc  = $urandom & ~32'h1;
            fa  = $urandom;
            v   = $urandom & 32'h0000_03FC;
            npc = $urandom & ~32'h1;
            sr  = 16'($urandom);
            ir  = 16'($urandom);
            run_seq(s, pc, sr, ir, fa, 1'($urandom), 1'($urandom), v, npc, -1);
        end

        // nested fault during frame write and during vector read
        run_seq(32'h0000_4000, 32'h0000_0200, 16'h0700, 16'h1234, 32'h0000_0003,
                1'b0, 1'b0, 32'h0000_000C, 32'h0000_0800, 3);
        do_reset();
        @(negedge clk);
        chk(!halt_o, "R10 reset clears halt", {31'd0, halt_o}, 0);
        run_seq(32'h0000_5000, 32'h0000_0300, 16'h2300, 16'h4321, 32'h0000_0005,
                1'b1, 1'b1, 32'h0000_0008, 32'h0000_0900, 7);
        do_reset();
        run_seq(32'h0000_6000, 32'h0000_0400, 16'h0000, 16'hFFFF, 32'h1234_5678,
                1'b1, 1'b0, 32'h0000_0010, 32'h0000_0A00, -1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule